// File: doc/BRIEF.md
# Reset Supervisor with Pushbutton and Watchdog

This block decides when the rest of a chip is held in reset. It takes three reset causes. The first is a power-fail flag from an outside voltage comparator. The second is an active-low pushbutton that must be held down long enough to count. The third is a watchdog that software must keep feeding with falling edges on a strobe input. Whenever any of these causes is present, and for a fixed number of millisecond ticks after the last one clears, the block drives a reset that is active-high on one output and active-low on the other.

All timing is counted in ticks of a 1 kHz enable input. The clock itself may run much faster. A two-bit select code sets the watchdog period to one of three lengths. The strobe and pushbutton inputs may change at any time and are synchronised inside the block. The power-fail flag is taken to be already synchronous to the clock, so it can act on the very next edge.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block forces `reset_out` to 1 and `reset_out_n` to 0. After `rst_n` rises, reset stays asserted for exactly `HOLD_TICKS` (default 610) ticks and then releases.
- R2: `reset_out_n` is always the logical inverse of `reset_out`.
- R3: A high `pwr_fail` at a clock edge makes `reset_out` 1 after that same edge.
- R4: When the last reset cause clears, reset stays asserted for exactly `HOLD_TICKS` further ticks and then releases. This holds after a power fail and after a watchdog expiry.
- R5: A low level on `pb_n` that lasts `PB_TICKS` (default 20) ticks or longer causes a reset. A low level that lasts fewer ticks has no effect on the outputs. With a tick on every clock, reset asserts 3 clocks after the press reaches its threshold, and the hold interval starts counting 3 clocks after `pb_n` returns high.
- R6: `wd_sel` sets the watchdog period: 2'b00 gives `WD_T0` (250) ticks, 2'b01 gives `WD_T1` (1000), 2'b10 gives `WD_T2` (2000), and 2'b11 behaves like 2'b01. With no strobe, reset re-asserts exactly that many ticks after it released.
- R7: Each high-to-low transition on `wd_strobe` restarts the watchdog period. Strobing faster than the period keeps reset released. With a tick on every clock, the period restarts 3 clocks after the edge is driven.
- R8: The watchdog does not count while reset is asserted. Its period is measured from the release of reset.
- R9: A new reset cause that appears during the hold interval restarts the interval from zero.
- R10: The hold and watchdog counters advance only on clocks where `tick_1k` is high. With no ticks, an asserted reset never releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick_1k | input | 1 | One-clock enable pulse, once per millisecond |
| pwr_fail | input | 1 | Supply-low flag from the outside comparator, active high, synchronous |
| pb_n | input | 1 | Pushbutton, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog feed; falling edges count, asynchronous |
| wd_sel | input | 2 | Watchdog period select |
| reset_out | output | 1 | Reset, active high |
| reset_out_n | output | 1 | Reset, active low |

## Verification
All four select codes are run with no strobe, so the measured re-assert delay separates the three periods and shows that code 11 is an alias. A single strobe placed late in a period shows whether an edge restarts the count or is ignored. Regular strobing shows that a fed watchdog stays quiet. Pushbutton presses are swept one tick at a time across the debounce threshold, which pins down the exact acceptance width. A second power fail in the middle of a hold interval, and a long stretch with no ticks, tell a restarting, tick-driven hold apart from a free-running one.

// File: rtl/rsup_pkg.sv
// Shared definitions for the reset supervisor.
// Assumes: the three watchdog periods are given in ticks, with T2 the largest.
package rsup_pkg;

    // Names for the watchdog period select codes
    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_ALIAS = 2'b11
    } wd_sel_e;

    // Map a select code to its period in ticks; the alias code uses the middle period
    function automatic int unsigned wd_limit(input logic [1:0] sel,
                                             input int unsigned t0,
                                             input int unsigned t1,
                                             input int unsigned t2);
        case (wd_sel_e'(sel))
            WD_SHORT: return t0;
            WD_LONG:  return t2;
            default:  return t1;
        endcase
    endfunction

endpackage

// File: rtl/rsup_sync.sv
// Two-flop synchroniser for a group of asynchronous single-bit inputs.
// Assumes: each bit is independent; RST_VAL is the idle level each bit takes in reset.
module rsup_sync #(
    parameter int unsigned W = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two register stages per bit to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/rsup_debounce.sv
// Pushbutton qualifier: reports a press once the synchronised button has been low
// for PB_TICKS consecutive ticks, and keeps reporting it while the button stays low.
// Assumes: pb_s is already synchronised; a high level clears the count at once.
module rsup_debounce #(
    parameter int unsigned PB_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pb_s,
    output logic pb_hit
);

    localparam int unsigned CW = $clog2(PB_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(PB_TICKS);

    logic [CW-1:0] low_cnt;

    // Count ticks of continuous low level, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (pb_s) begin
            low_cnt <= '0;
        end else if (tick && (low_cnt != FULL)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign pb_hit = (low_cnt == FULL);

    // R5
    pb_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pb_hit) |-> $past(!pb_s));

    // R5
    pb_hit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_hit && pb_s) |=> !pb_hit);

endmodule

// File: rtl/rsup_watchdog.sv
// Watchdog timer: restarts on each falling edge of the synchronised strobe and
// gives a one-clock trip pulse when the selected period passes with no edge.
// Assumes: hold is high while reset is asserted; the count stays cleared then.
module rsup_watchdog
    import rsup_pkg::*;
#(
    parameter int unsigned WD_T0 = 250,
    parameter int unsigned WD_T1 = 1000,
    parameter int unsigned WD_T2 = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       strobe_s,
    input  logic       hold,
    input  logic [1:0] sel,
    output logic       trip
);

    localparam int unsigned TMAX = (WD_T2 > WD_T1) ? ((WD_T2 > WD_T0) ? WD_T2 : WD_T0)
                                                   : ((WD_T1 > WD_T0) ? WD_T1 : WD_T0);
    localparam int unsigned CW = $clog2(TMAX + 1);

    logic          strobe_q;
    logic          fall_edge;
    logic [CW-1:0] wd_cnt;
    logic [CW-1:0] limit;

    // Remember the previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_s;
    end

    assign fall_edge = strobe_q && !strobe_s;
    assign limit     = CW'(wd_limit(sel, WD_T0, WD_T1, WD_T2));
    assign trip      = !hold && tick && (wd_cnt >= limit - 1'b1);

    // Count ticks since release or since the last strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_cnt <= '0;
        end else if (hold || fall_edge || trip) begin
            wd_cnt <= '0;
        end else if (tick) begin
            wd_cnt <= wd_cnt + 1'b1;
        end
    end

    // R8
    wd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (wd_cnt == '0));

    // R6
    wd_trip_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> hold);

    // R7
    wd_edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_edge && !hold) |=> (wd_cnt == '0));

endmodule

// File: rtl/rsup_stretch.sv
// Reset stretcher: asserts reset while any cause is present and keeps it asserted
// for HOLD_TICKS ticks after the last cause clears. A new cause restarts the hold.
// Assumes: cause is synchronous to clk; HOLD_TICKS is at least 2.
module rsup_stretch #(
    parameter int unsigned HOLD_TICKS = 610
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic rst_hi,
    output logic rst_lo
);

    localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] hold_cnt;

    // Drive both polarities from separate registers and count the hold interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_hi   <= 1'b1;
            rst_lo   <= 1'b0;
            hold_cnt <= '0;
        end else if (cause) begin
            rst_hi   <= 1'b1;
            rst_lo   <= 1'b0;
            hold_cnt <= '0;
        end else if (rst_hi && tick) begin
            if (hold_cnt == LAST) begin
                rst_hi   <= 1'b0;
                rst_lo   <= 1'b1;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // R2
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hi != rst_lo);

    // R3
    cause_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> rst_hi);

    // R4
    release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_hi) |-> ($past(tick) && !$past(cause) && ($past(hold_cnt) == LAST)));

    // R10
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cause) |=> $stable(rst_hi));

endmodule

// File: rtl/rst_supervisor.sv
// Reset supervisor top: synchronises the pushbutton and watchdog strobe, qualifies
// the button, runs the watchdog and stretches the combined cause into a reset.
// Assumes: tick_1k is a one-clock pulse per millisecond; pwr_fail is synchronous.
module rst_supervisor #(
    parameter int unsigned HOLD_TICKS = 610,
    parameter int unsigned PB_TICKS   = 20,
    parameter int unsigned WD_T0      = 250,
    parameter int unsigned WD_T1      = 1000,
    parameter int unsigned WD_T2      = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1k,
    input  logic       pwr_fail,
    input  logic       pb_n,
    input  logic       wd_strobe,
    input  logic [1:0] wd_sel,
    output logic       reset_out,
    output logic       reset_out_n
);

    logic [1:0] raw_in;
    logic [1:0] sync_in;
    logic       pb_hit;
    logic       wd_trip;
    logic       cause;

    assign raw_in = {pb_n, wd_strobe};

    rsup_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    rsup_debounce #(.PB_TICKS(PB_TICKS)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1k),
        .pb_s   (sync_in[1]),
        .pb_hit (pb_hit)
    );

    rsup_watchdog #(.WD_T0(WD_T0), .WD_T1(WD_T1), .WD_T2(WD_T2)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1k),
        .strobe_s (sync_in[0]),
        .hold     (reset_out),
        .sel      (wd_sel),
        .trip     (wd_trip)
    );

    assign cause = pwr_fail || pb_hit || wd_trip;

    rsup_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_str (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1k),
        .cause  (cause),
        .rst_hi (reset_out),
        .rst_lo (reset_out_n)
    );

    // R3
    pwr_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> reset_out);

    // R1
    por_chk: assert property (@(posedge clk)
        !rst_n |=> (reset_out && !reset_out_n));

endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;

    localparam int HOLD = 610;
    localparam int PBT  = 20;
    localparam int T0   = 250;
    localparam int T1   = 1000;
    localparam int T2   = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_on = 1'b1;
    logic       pwr_fail = 1'b0;
    logic       pb_n = 1'b1;
    logic       wd_strobe = 1'b1;
    logic [1:0] wd_sel = 2'b00;
    logic       reset_out;
    logic       reset_out_n;
    logic       strobe_en = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int compl_bad = 0;

    always #5 clk = ~clk;

    rst_supervisor uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1k     (tick_on),
        .pwr_fail    (pwr_fail),
        .pb_n        (pb_n),
        .wd_strobe   (wd_strobe),
        .wd_sel      (wd_sel),
        .reset_out   (reset_out),
        .reset_out_n (reset_out_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling clock edges until reset_out reaches val
    task automatic until_reset(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (reset_out !== val && n < 20000);
    endtask

    // Drive a power-fail pulse; returns at the edge where it is dropped
    task automatic pwr_pulse();
        @(negedge clk);
        pwr_fail = 1'b1;
        repeat (3) @(negedge clk);
        pwr_fail = 1'b0;
    endtask

    function automatic int period_of(input logic [1:0] s);
        return (s == 2'b00) ? T0 : (s == 2'b10) ? T2 : T1;
    endfunction

    // R2 polarity monitor
    always @(negedge clk) if (rst_n && (reset_out === reset_out_n)) compl_bad++;

    // Background strobe: falling edge every 100 clocks while enabled
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (strobe_en) begin
                ph = (ph + 1) % 100;
                wd_strobe = (ph >= 2);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset_out in reset", int'(reset_out), 1);
        chk("R2 reset_out_n in reset", int'(reset_out_n), 0);
        rst_n = 1'b1;
        until_reset(1'b0, n);
        chk("R1 power-on hold", n, HOLD);

        // R6 R8 R4: sweep every select code with no strobe
        for (int s = 0; s < 4; s++) begin
            wd_sel = 2'(s);
            pwr_pulse();
            until_reset(1'b0, n);
            chk("R4 hold after power fail", n, HOLD);
            until_reset(1'b1, n);
            chk("R6 R8 watchdog period from release", n, period_of(2'(s)));
            until_reset(1'b0, n);
            chk("R4 hold after watchdog trip", n, HOLD);
        end

        // R7: one strobe late in the period restarts it
        wd_sel = 2'b00;
        pwr_pulse();
        until_reset(1'b0, n);
        repeat (200) @(negedge clk);
        chk("R7 still released before strobe", int'(reset_out), 0);
        wd_strobe = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 2) wd_strobe = 1'b1;
        end while (reset_out !== 1'b1 && n < 20000);
        chk("R7 period restarted by strobe edge", n, T0 + 3);
        until_reset(1'b0, n);

        // R7: regular strobing keeps reset released
        strobe_en = 1'b1;
        repeat (3 * T0) @(negedge clk);
        chk("R7 fed watchdog stays quiet", int'(reset_out), 0);

        // R3: power fail acts on the next edge
        @(negedge clk);
        pwr_fail = 1'b1;
        @(negedge clk);
        chk("R3 prompt assert", int'(reset_out), 1);
        pwr_fail = 1'b0;

        // R9: second power fail in mid-hold restarts the interval
        repeat (300) @(negedge clk);
        pwr_pulse();
        until_reset(1'b0, n);
        chk("R9 hold restarted", n, HOLD);

        // R5: sweep press width across the threshold
        for (int w = PBT - 3; w <= PBT + 2; w++) begin
            repeat (20) @(negedge clk);
            pb_n = 1'b0;
            repeat (w) @(negedge clk);
            pb_n = 1'b1;
            repeat (10) @(negedge clk);
            chk($sformatf("R5 press width %0d", w), int'(reset_out), (w >= PBT) ? 1 : 0);
            if (reset_out) until_reset(1'b0, n);
        end

        // R5: hold starts 3 clocks after release of a long press
        @(negedge clk);
        pb_n = 1'b0;
        repeat (40) @(negedge clk);
        pb_n = 1'b1;
        until_reset(1'b0, n);
        chk("R5 hold after long press", n, HOLD + 3);

        // R10: no ticks, no release
        tick_on = 1'b0;
        pwr_pulse();
        repeat (1500) @(negedge clk);
        chk("R10 reset held without ticks", int'(reset_out), 1);
        tick_on = 1'b1;
        until_reset(1'b0, n);
        chk("R10 hold counts from first tick", n, HOLD);

        chk("R2 complementary outputs", compl_bad, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule